// File: doc/BRIEF.md
# Fast PWM Timer with Buffered Top

An up-counting timer for pulse-width modulation. On each cycle where the tick enable is high, the counter advances by one. When it equals the selected TOP value, it returns to zero on that tick instead. TOP has three possible sources, chosen by a 2-bit field:

- a fixed 8-, 9- or 10-bit all-ones value;
- the active value of compare channel A;
- a top register that takes effect as soon as it is written.

Two compare channels, A and B, each hold a write buffer and an active compare value. A channel's active value is reloaded from its buffer only on the tick where the counter goes from TOP to zero. This lets software change the period and duty at any time without producing a broken pulse.

Each channel drives one pin in one of three ways: held low, non-inverted PWM or inverted PWM. Four sticky flags record these events:

- overflow at TOP;
- a compare match on channel A;
- a compare match on channel B;
- TOP reached while the top register is the source.

Software clears a flag by writing a one to its bit.

The counter's phase is decoded as one of three states:

- `PH_BELOW`: count is under TOP.
- `PH_AT`: count equals TOP.
- `PH_ABOVE`: count is over TOP.

These states have three transitions:

- `PH_AT` to zero on a tick.
- `PH_BELOW` counts up one on a tick.
- `PH_ABOVE` counts up through 0xFFFF and wraps to zero. This is the recovery path after TOP is lowered below the current count.

Top module: `pwm_timer16`

## Requirements
- R1: The counter changes only on cycles with `tick` high. On such a cycle, when it is not at TOP, it increments by one modulo 2^16.
- R2: On a tick where count equals TOP, the count becomes 0 and `flags_o[0]` (overflow) is set. When the count passes from 0xFFFF to 0 while not at TOP, the overflow flag is not set.
- R3: `top_src` chooses where TOP comes from:
  - 0 and 3 select a fixed value, picked by `fix_sel`: 0 gives 0x00FF, 1 gives 0x01FF, and 2 or 3 give 0x03FF.
  - 1 selects the active compare A value.
  - 2 selects the top register.
- R4: A write to compare A or B goes to that channel's buffer. The active compare value takes the buffer contents only on a tick where count equals TOP. Until then the period and match point keep the old value.
- R5: The top register is used as soon as it is written. If it is written below the current count while source 2 is selected, the counter runs up to 0xFFFF, wraps to 0 without an overflow flag, and then returns to zero at the new TOP.
- R6: Output mode 2 (non-inverted) updates the pin as follows:
  - It clears the pin after a tick where count equals the channel's active compare value.
  - It sets the pin after a TOP-to-zero tick.
  - When both happen on the same tick, the set wins.
- R7: Output mode 3 (inverted) sets the pin after a compare-match tick and clears it after a TOP-to-zero tick. When both happen on the same tick, the clear wins.
- R8: Output modes 0 and 1 drive the channel pin to 0 from the next clock edge onward.
- R9: The compare and top-register flags behave as follows:
  - `flags_o[1]` (A) and `flags_o[2]` (B) are set on a tick where the count equals that channel's active compare value. A channel whose compare value is above TOP never sets its flag.
  - With source 1, flag A is set on the same tick as the overflow flag.
  - `flags_o[3]` is set on a TOP-to-zero tick while source 2 is selected.
- R10: While a fixed TOP is selected, compare writes store `wr_data` AND the fixed TOP, so bits above the TOP width become zero.
- R11: A one in bit i of `flag_clr` clears `flags_o[i]`. If the flag's event happens in the same cycle, the set wins. A cleared bit otherwise stays set.
- R12: After reset, the following are all zero: the count, all flags, both pins, both compare buffers, both active compare values and the top register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer tick enable (prescaler output) |
| top_src | input | 2 | TOP source: 0/3 fixed, 1 compare A, 2 top register |
| fix_sel | input | 2 | Fixed TOP width: 0 8-bit, 1 9-bit, 2/3 10-bit |
| wr_cmpa | input | 1 | Write strobe for compare A buffer |
| wr_cmpb | input | 1 | Write strobe for compare B buffer |
| wr_top | input | 1 | Write strobe for the top register |
| wr_data | input | 16 | Write data for all three registers |
| mode_a | input | 2 | Output mode of channel A |
| mode_b | input | 2 | Output mode of channel B |
| flag_clr | input | 4 | Write-one-to-clear mask for the flags |
| count_o | output | 16 | Current count |
| flags_o | output | 4 | Sticky flags: [0] overflow, [1] match A, [2] match B, [3] top-register TOP |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |

## Verification
A wrong active compare or TOP value shows up on `count_o` within one period: the count returns to zero at the wrong place, or it runs on into the 0xFFFF overrun. A stale or early buffer load moves the point where `pwm_a` or `pwm_b` toggles in the very next period, and sets the match flag at the wrong count. The bench carries a cycle-level model of the requirements and compares the count, the flags and both pins after every clock edge. A misplaced load, mask or priority is therefore reported on the first cycle where it becomes visible, not at the end of a period.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    typedef enum logic [1:0] {
        SRC_FIXED  = 2'd0,
        SRC_CMPA   = 2'd1,
        SRC_TREG   = 2'd2,
        SRC_FIXED2 = 2'd3
    } top_src_e;

    typedef enum logic [1:0] {
        OM_OFF0 = 2'd0,
        OM_OFF1 = 2'd1,
        OM_NORM = 2'd2,
        OM_INV  = 2'd3
    } out_mode_e;

    typedef enum logic [1:0] {
        PH_BELOW = 2'd0,
        PH_AT    = 2'd1,
        PH_ABOVE = 2'd2
    } phase_e;

    localparam int NUM_CH    = 2;
    localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/ptm_top_sel.sv
module ptm_top_sel
    import ptm_pkg::*;
#(
    parameter int W        = 16,
    parameter int FIX_BASE = 8
) (
    input  logic [1:0]   src,
    input  logic [1:0]   fix_sel,
    input  logic [W-1:0] cmpa_act,
    input  logic [W-1:0] treg,
    output logic [W-1:0] top_val,
    output logic [W-1:0] wr_mask
);

    logic [1:0]   sh;
    logic [W-1:0] fixed_top;

    // fixed TOP = all-ones of FIX_BASE + sh bits
    always_comb begin
        sh = (fix_sel == 2'd3) ? 2'd2 : fix_sel;
        for (int i = 0; i < W; i++) begin
            fixed_top[i] = (i < FIX_BASE + int'(sh));
        end
    end

    always_comb begin
        unique case (top_src_e'(src))
            SRC_CMPA: begin
                top_val = cmpa_act;
                wr_mask = '1;
            end
            SRC_TREG: begin
                top_val = treg;
                wr_mask = '1;
            end
            SRC_FIXED, SRC_FIXED2: begin
                top_val = fixed_top;
                wr_mask = fixed_top;
            end
            default: begin
                top_val = fixed_top;
                wr_mask = fixed_top;
            end
        endcase
    end

endmodule

// File: rtl/ptm_counter.sv
module ptm_counter
    import ptm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] count,
    output phase_e       phase,
    output logic         wrap_tick
);

    logic [W-1:0] nxt;

    // phase decode: where the count stands against TOP
    always_comb begin
        if (count == top_val)     phase = PH_AT;
        else if (count < top_val) phase = PH_BELOW;
        else                      phase = PH_ABOVE;
    end

    // transitions: PH_AT -> zero, PH_BELOW/PH_ABOVE -> +1 (ABOVE wraps at max)
    always_comb begin
        unique case (phase)
            PH_AT:              nxt = '0;
            PH_BELOW, PH_ABOVE: nxt = count + W'(1);
            default:            nxt = count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= nxt;
    end

    assign wrap_tick = tick && (phase == PH_AT);

endmodule

// File: rtl/ptm_channel.sv
module ptm_channel
    import ptm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wrap_tick,
    input  logic [W-1:0] count,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [1:0]   mode,
    output logic [W-1:0] act,
    output logic         match,
    output logic         pin
);

    logic [W-1:0] shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     shadow <= '0;
        else if (wr_en) shadow <= wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         act <= '0;
        else if (wrap_tick) act <= shadow;
    end

    assign match = tick && (count == act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else begin
            unique case (out_mode_e'(mode))
                OM_OFF0, OM_OFF1: pin <= 1'b0;
                OM_NORM: begin
                    if (wrap_tick)  pin <= 1'b1;
                    else if (match) pin <= 1'b0;
                end
                OM_INV: begin
                    if (wrap_tick)  pin <= 1'b0;
                    else if (match) pin <= 1'b1;
                end
                default: pin <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
    import ptm_pkg::*;
#(
    parameter int W        = 16,
    parameter int FIX_BASE = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   top_src,
    input  logic [1:0]   fix_sel,
    input  logic         wr_cmpa,
    input  logic         wr_cmpb,
    input  logic         wr_top,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    input  logic [3:0]   flag_clr,
    output logic [W-1:0] count_o,
    output logic [3:0]   flags_o,
    output logic         pwm_a,
    output logic         pwm_b
);

    logic [W-1:0] top_val;
    logic [W-1:0] wr_mask;
    logic [W-1:0] treg;
    logic         wrap_tick;
    phase_e       phase;

    logic [W-1:0] act_c   [NUM_CH];
    logic         match_c [NUM_CH];
    logic         pin_c   [NUM_CH];
    logic         wr_c    [NUM_CH];
    logic [1:0]   mode_c  [NUM_CH];

    assign wr_c[0]   = wr_cmpa;
    assign wr_c[1]   = wr_cmpb;
    assign mode_c[0] = mode_a;
    assign mode_c[1] = mode_b;

    ptm_top_sel #(.W(W), .FIX_BASE(FIX_BASE)) u_sel (
        .src      (top_src),
        .fix_sel  (fix_sel),
        .cmpa_act (act_c[0]),
        .treg     (treg),
        .top_val  (top_val),
        .wr_mask  (wr_mask)
    );

    ptm_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .top_val   (top_val),
        .count     (count_o),
        .phase     (phase),
        .wrap_tick (wrap_tick)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ptm_channel #(.W(W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .wrap_tick (wrap_tick),
            .count     (count_o),
            .wr_en     (wr_c[g]),
            .wr_val    (wr_data & wr_mask),
            .mode      (mode_c[g]),
            .act       (act_c[g]),
            .match     (match_c[g]),
            .pin       (pin_c[g])
        );
    end

    // top register: no buffer, used at once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      treg <= '0;
        else if (wr_top) treg <= wr_data;
    end

    logic [NUM_FLAGS-1:0] flag_set;
    assign flag_set = {wrap_tick && (top_src_e'(top_src) == SRC_TREG),
                       match_c[1], match_c[0], wrap_tick};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~flag_clr) | flag_set;
    end

    assign pwm_a = pin_c[0];
    assign pwm_b = pin_c[1];

endmodule

// File: rtl/ptm_chk.sv
module ptm_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [W-1:0] count_o,
    input logic [W-1:0] top_val,
    input logic [3:0]   flags_o,
    input logic [3:0]   flag_clr,
    input logic [1:0]   mode_a,
    input logic [1:0]   mode_b,
    input logic         pwm_a,
    input logic         pwm_b
);

    // R2
    wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_o == top_val) |=> (count_o == '0 && flags_o[0]));

    // R1
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_o));

    // R1
    step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_o != top_val) |=> (count_o == W'($past(count_o) + W'(1))));

    // R2
    no_false_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_o != top_val && !flags_o[0]) |=> !flags_o[0]);

    // R8
    idle_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a < 2'd2) |=> !pwm_a);

    // R8
    idle_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b < 2'd2) |=> !pwm_b);

    // R11
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[0] && !flag_clr[0]) |=> flags_o[0]);

endmodule

bind pwm_timer16 ptm_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .count_o  (count_o),
    .top_val  (top_val),
    .flags_o  (flags_o),
    .flag_clr (flag_clr),
    .mode_a   (mode_a),
    .mode_b   (mode_b),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b)
);

// File: tb/sim_pwm_timer16.sv
`timescale 1ns/1ps
module sim_pwm_timer16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  top_src = 2'd0;
    logic [1:0]  fix_sel = 2'd0;
    logic        wr_cmpa = 1'b0;
    logic        wr_cmpb = 1'b0;
    logic        wr_top = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  mode_a = 2'd0;
    logic [1:0]  mode_b = 2'd0;
    logic [3:0]  flag_clr = 4'h0;
    logic [15:0] count_o;
    logic [3:0]  flags_o;
    logic        pwm_a;
    logic        pwm_b;

    always #10 clk = ~clk;

    pwm_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top_src(top_src), .fix_sel(fix_sel),
        .wr_cmpa(wr_cmpa), .wr_cmpb(wr_cmpb), .wr_top(wr_top), .wr_data(wr_data),
        .mode_a(mode_a), .mode_b(mode_b), .flag_clr(flag_clr),
        .count_o(count_o), .flags_o(flags_o), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    typedef struct packed {
        logic [15:0] c;
        logic [3:0]  f;
        logic        a;
        logic        b;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    int   maxc  = 0;

    // model state
    logic [15:0] m_cnt = 0, m_bufa = 0, m_acta = 0, m_bufb = 0, m_actb = 0, m_treg = 0;
    logic [3:0]  m_flags = 0;
    logic        m_pa = 0, m_pb = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] fixed_top(input logic [1:0] s);
        return (s == 2'd0) ? 16'h00FF : (s == 2'd1) ? 16'h01FF : 16'h03FF;
    endfunction

    function automatic logic pnext(input logic [1:0] m, input logic p, input logic w, input logic mt);
        if (m < 2'd2) return 1'b0;
        if (w)        return (m == 2'd2);
        if (mt)       return (m == 2'd3);
        return p;
    endfunction

    // driver: drive one cycle at the falling edge and push the expected result
    task automatic step(input bit t, input bit wa = 0, input bit wb = 0, input bit wt = 0,
                        input logic [15:0] d = 16'h0, input logic [3:0] clr = 4'h0);
        logic [15:0] top, mask;
        logic        at, w, ma, mb;
        exp_t        e;
        @(negedge clk);
        tick = t; wr_cmpa = wa; wr_cmpb = wb; wr_top = wt; wr_data = d; flag_clr = clr;
        top  = (top_src == 2'd1) ? m_acta : (top_src == 2'd2) ? m_treg : fixed_top(fix_sel);
        mask = (top_src == 2'd1 || top_src == 2'd2) ? 16'hFFFF : fixed_top(fix_sel);
        at = (m_cnt == top);
        w  = t && at;
        ma = t && (m_cnt == m_acta);
        mb = t && (m_cnt == m_actb);
        m_pa    = pnext(mode_a, m_pa, w, ma);
        m_pb    = pnext(mode_b, m_pb, w, mb);
        m_flags = (m_flags & ~clr) | {w && (top_src == 2'd2), mb, ma, w};
        if (t) m_cnt = at ? 16'h0 : m_cnt + 16'h1;
        if (w) begin m_acta = m_bufa; m_actb = m_bufb; end
        if (wa) m_bufa = d & mask;
        if (wb) m_bufb = d & mask;
        if (wt) m_treg = d;
        e.c = m_cnt; e.f = m_flags; e.a = m_pa; e.b = m_pb;
        exp_q.push_back(e);
        @(posedge clk);
        #2;
        tick = 0; wr_cmpa = 0; wr_cmpb = 0; wr_top = 0; flag_clr = 4'h0;
        if (int'(count_o) > maxc) maxc = int'(count_o);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic run_to_zero();
        step(1'b1);
        while (count_o != 16'h0) step(1'b1);
    endtask

    // monitor: compare after every edge that follows a driven cycle
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(count_o == e.c, "R1 R5 count", count_o, e.c);
            chk(flags_o == e.f, "R2 R9 R11 flags", flags_o, e.f);
            chk(pwm_a == e.a, "R6 R8 pwm_a", pwm_a, e.a);
            chk(pwm_b == e.b, "R7 R8 pwm_b", pwm_b, e.b);
        end
    end

    initial begin
        #(20 * 180000);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int c0, nt;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R12 reset state
        chk(count_o == 0, "R12 count", count_o, 0);
        chk(flags_o == 0, "R12 flags", flags_o, 0);
        chk(pwm_a == 0 && pwm_b == 0, "R12 pins", {pwm_a, pwm_b}, 0);

        // fixed 8-bit TOP, masked writes (R10, R3)
        mode_a = 2'd2; mode_b = 2'd3;
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'h1234);
        step(1'b1, 1'b0, 1'b1, 1'b0, 16'hFF80);
        run_to_zero();
        step(1'b0, 0, 0, 0, 16'h0, 4'hF);
        maxc = 0;
        run(256);
        chk(maxc == 16'h00FF, "R3 fixed 8-bit top", maxc, 16'hFF);
        chk(flags_o[1] == 1'b1, "R10 masked A match at 0x34", flags_o[1], 1);
        chk(flags_o[2] == 1'b1, "R10 masked B match at 0x80", flags_o[2], 1);

        // wider fixed tops, source code 3 (R3)
        fix_sel = 2'd1; maxc = 0; run(512);
        chk(maxc == 16'h01FF, "R3 fixed 9-bit top", maxc, 16'h1FF);
        fix_sel = 2'd2; maxc = 0; run(1024);
        chk(maxc == 16'h03FF, "R3 fixed 10-bit top", maxc, 16'h3FF);
        fix_sel = 2'd3; top_src = 2'd3; maxc = 0; run(1024);
        chk(maxc == 16'h03FF, "R3 source 3 fixed", maxc, 16'h3FF);

        // irregular tick pattern (R1)
        c0 = int'(count_o); nt = 0;
        for (int i = 0; i < 400; i++) begin
            bit t;
            t = 1'($urandom_range(0, 1));
            nt += int'(t);
            step(t);
        end
        chk(int'(count_o) == c0 + nt, "R1 ticks counted", count_o, c0 + nt);
        run_to_zero();

        // compare A as TOP, buffered (R4, R9)
        top_src = 2'd1;
        step(1'b0, 0, 0, 0, 16'h0, 4'hF);
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'd100);
        maxc = 0; run_to_zero();
        chk(maxc == 52, "R4 old TOP kept until wrap", maxc, 52);
        maxc = 0; run_to_zero();
        chk(maxc == 100, "R4 new TOP after wrap", maxc, 100);
        chk(flags_o[2] == 1'b0, "R9 B above TOP no match", flags_o[2], 0);
        chk(flags_o[1:0] == 2'b11, "R9 A flag with overflow", flags_o[1:0], 3);

        // write-one-to-clear (R11)
        step(1'b0, 0, 0, 0, 16'h0, 4'b0001);
        chk(flags_o[0] == 1'b0, "R11 cleared bit", flags_o[0], 0);
        chk(flags_o[1] == 1'b1, "R11 other bit kept", flags_o[1], 1);

        // disconnected modes (R8)
        mode_a = 2'd0; mode_b = 2'd1;
        run(150);
        chk(pwm_a == 0 && pwm_b == 0, "R8 pins low", {pwm_a, pwm_b}, 0);

        // inverted output (R7)
        mode_a = 2'd2; mode_b = 2'd3;
        step(1'b0, 1'b0, 1'b1, 1'b0, 16'd40);
        run_to_zero(); run_to_zero();
        run(20);
        chk(pwm_a == 1'b1, "R6 compare at TOP keeps high", pwm_a, 1);
        chk(pwm_b == 1'b0, "R7 low before match", pwm_b, 0);
        run(25);
        chk(pwm_b == 1'b1, "R7 high after match", pwm_b, 1);

        // top register, late write (R5, R6)
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'd1000);
        step(1'b0, 1'b1, 1'b0, 1'b0, 16'd300);
        run_to_zero();
        top_src = 2'd2;
        run(200);
        chk(pwm_a == 1'b1, "R6 high before match", pwm_a, 1);
        run(200);
        chk(count_o == 400, "R5 long period", count_o, 400);
        chk(pwm_a == 1'b0, "R6 low after match", pwm_a, 0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'd100);
        step(1'b0, 0, 0, 0, 16'h0, 4'hF);
        run(65536 - 400);
        chk(count_o == 0, "R5 wrapped past max", count_o, 0);
        chk(flags_o[0] == 1'b0, "R2 no overflow on natural wrap", flags_o[0], 0);
        chk(flags_o[3] == 1'b0, "R9 no top flag on natural wrap", flags_o[3], 0);
        run(100);
        chk(count_o == 100 && flags_o[0] == 1'b0, "R5 reached new TOP", count_o, 100);
        run(1);
        chk(count_o == 0, "R5 cleared at new TOP", count_o, 0);
        chk(flags_o[0] && flags_o[3], "R9 top flag with overflow", flags_o, 4'h9);

        @(posedge clk); #3;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule